// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Status

This block takes an asynchronous serial line and turns each character into a byte in a single receive data register. It also produces a status word that reports what went wrong with that character. A 16x oversampling tick from outside sets the bit timing. A start edge is confirmed at mid-bit, and each following bit is sampled at its centre. Eight data bits are received least significant bit first. They are followed by an optional parity bit and one or two stop bits, chosen by mode inputs.

The error flags describe only the character currently held in the register; they are not sticky. Each stored character brings its own parity and framing verdict, which replaces the old one. The overrun flag reports that an unread character was replaced. A single-cycle host read strobe on the data register clears the data-valid flag and every error flag together. The mode inputs must be held steady while a character is on the line.

Top module: `uart_rx_errstat`

## Requirements
- R1: After reset, `status_o` reads 10'h200 and `data_o` reads 0.
- R2: In `status_o`, bit 9 always reads 1, and bits 8, 7, 2 and 1 always read 0.
- R3: A character is stored when its last configured stop bit has been sampled, 12+16*N clock cycles after the falling start edge, where N is the number of bits after the start bit. This timing assumes a tick on every clock. Storing a character places the eight data bits, least significant first, on `data_o` and sets the data-valid flag, status bit 0.
- R4: A start bit that samples high at its midpoint (8 ticks after detection) is dropped. No character is stored and the status does not change.
- R5: With `par_en_i` high, one parity bit follows the data. Status bit 3 is set when the data and parity bits together hold an odd number of ones and `par_odd_i` is 0, or an even number and `par_odd_i` is 1. With `par_en_i` low, no parity bit is received and bit 3 stays 0.
- R6: Status bit 4 (framing) is set when the stop bit samples low. With `two_stop_i` high, it is also set when the second stop bit samples low. It is cleared when every configured stop bit samples high.
- R7: Status bit 5 (overrun) is set when a character is stored while the data-valid flag is still set and no read is strobed. The newer character replaces the older one on `data_o`.
- R8: A character stored before the host reads rewrites the parity and framing flags from its own status. Earlier flags are lost. Outside a store or a read, no flag changes.
- R9: A read strobe `rd_i` with no store in the same cycle clears status bits 0, 3, 4, 5 and 6 at the next edge.
- R10: Status bit 6 reads 1 exactly when any of bits 3, 4 or 5 is 1.
- R11: When a read strobe and a store fall in the same cycle, the store wins. The new character and flags are loaded, data-valid stays 1, and overrun is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | 16x oversampling enable, one pulse per sixteenth of a bit |
| rxd_i | input | 1 | Serial input, idle high |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | 1: two stop bits expected, 0: one |
| rd_i | input | 1 | Data register read strobe, one cycle |
| data_o | output | 8 | Receive data register |
| status_o | output | 10 | Status word: 9 fixed 1, 6 any error, 5 overrun, 4 framing, 3 parity, 0 data valid |

## Verification
The hardest case to reach is a read strobe that lands in exactly the cycle a new character is stored (R11). It is a single-cycle window at the end of a frame of about 160 cycles. The bench computes the store cycle from the edge on which it drops the start bit, counting the two synchroniser stages, the half-bit start check, sixteen cycles per bit and the register between the framer and the data register. A parallel thread then raises `rd_i` on the negative edge just before that cycle. A behavioural model driven by the same computed event times is compared with every output on every clock. It catches an off-by-one in that window as well as overrun and flag-replacement errors.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
  } rx_err_t;

  localparam int STAT_W     = 10;
  localparam int STAT_VALID = 0;
  localparam int STAT_PERR  = 3;
  localparam int STAT_FERR  = 4;
  localparam int STAT_OVR   = 5;
  localparam int STAT_ANY   = 6;
  localparam int STAT_ONE   = 9;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE   = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  input  logic                 two_stop_i,
  output logic                 store_o,
  output logic [DATA_BITS-1:0] data_o,
  output rx_err_t              err_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 perr_q;
  logic                 stop1_bad_q;
  logic                 store_q;
  rx_err_t              err_q;

  wire at_last = (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shift_q     <= '0;
      perr_q      <= 1'b0;
      stop1_bad_q <= 1'b0;
      store_q     <= 1'b0;
      err_q       <= '0;
    end else begin
      store_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == MID_CNT) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              // line back high at mid-start: glitch
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_last) begin
              cnt_q   <= '0;
              shift_q <= {rx_i, shift_q[DATA_BITS-1:1]};
              if (idx_q == LAST_IDX) begin
                perr_q  <= 1'b0;
                state_q <= par_en_i ? ST_PAR : ST_STOP1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_last) begin
              cnt_q   <= '0;
              perr_q  <= (^shift_q) ^ rx_i ^ par_odd_i;
              state_q <= ST_STOP1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP1: begin
            if (at_last) begin
              cnt_q <= '0;
              if (two_stop_i) begin
                stop1_bad_q <= !rx_i;
                state_q     <= ST_STOP2;
              end else begin
                store_q    <= 1'b1;
                err_q.perr <= perr_q;
                err_q.ferr <= !rx_i;
                state_q    <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            if (at_last) begin
              cnt_q      <= '0;
              store_q    <= 1'b1;
              err_q.perr <= perr_q;
              err_q.ferr <= stop1_bad_q | !rx_i;
              state_q    <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign store_o = store_q;
  assign data_o  = shift_q;
  assign err_o   = err_q;

  AST_STORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_q |=> !store_q) else $error("store not a single pulse"); // R3

  AST_GLITCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == ST_START && cnt_q == MID_CNT && rx_i)
      |=> (state_q == ST_IDLE && !store_q)) else $error("glitch not dropped"); // R4

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 store_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  rx_err_t              err_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 perr_o,
  output logic                 ferr_o,
  output logic                 ovr_o
);
  logic [DATA_BITS-1:0] data_q;
  logic valid_q, perr_q, ferr_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (store_i) begin
      // store wins over a same-cycle read
      data_q  <= data_i;
      perr_q  <= err_i.perr;
      ferr_q  <= err_i.ferr;
      ovr_q   <= valid_q & ~rd_i;
      valid_q <= 1'b1;
    end else if (rd_i) begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign ovr_o   = ovr_q;

  AST_STORE_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> valid_q) else $error("store left valid low"); // R3

  AST_OVR_ON_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && valid_q && !rd_i) |=> ovr_q) else $error("overrun missed"); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!store_i && !rd_i) |=> $stable({valid_q, perr_q, ferr_q, ovr_q, data_q}))
    else $error("flags moved without store or read"); // R8

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !store_i) |=> !(valid_q | perr_q | ferr_q | ovr_q))
    else $error("read left a flag set"); // R9

  AST_STORE_BEATS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && store_i) |=> (valid_q && !ovr_q)) else $error("read-store collision"); // R11

endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 os_tick_i,
  input  logic                 rxd_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  input  logic                 two_stop_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic [STAT_W-1:0]    status_o
);
  logic                 rx_s;
  logic                 store;
  logic [DATA_BITS-1:0] frame_data;
  rx_err_t              frame_err;
  logic valid, perr, ferr, ovr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rx_s)
  );

  uart_rx_frame #(.OS_RATE(OS_RATE), .DATA_BITS(DATA_BITS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (os_tick_i),
    .rx_i       (rx_s),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .store_o    (store),
    .data_o     (frame_data),
    .err_o      (frame_err)
  );

  uart_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .store_i (store),
    .data_i  (frame_data),
    .err_i   (frame_err),
    .rd_i    (rd_i),
    .data_o  (data_o),
    .valid_o (valid),
    .perr_o  (perr),
    .ferr_o  (ferr),
    .ovr_o   (ovr)
  );

  always_comb begin
    status_o             = '0;
    status_o[STAT_ONE]   = 1'b1;
    status_o[STAT_ANY]   = perr | ferr | ovr;
    status_o[STAT_OVR]   = ovr;
    status_o[STAT_FERR]  = ferr;
    status_o[STAT_PERR]  = perr;
    status_o[STAT_VALID] = valid;
  end

  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[9:7] == 3'b100 && status_o[2:1] == 2'b00) else $error("fixed bits"); // R2

endmodule

// File: tb/uart_rx_errstat_tb_top.sv
`timescale 1ns/1ps
module uart_rx_errstat_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_tick_i = 1'b1;
  logic       rxd_i = 1'b1;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       two_stop_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic [9:0] status_o;

  always #10 clk_i = ~clk_i;

  uart_rx_errstat dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .os_tick_i(os_tick_i), .rxd_i(rxd_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .two_stop_i(two_stop_i),
    .rd_i(rd_i), .data_o(data_o), .status_o(status_o)
  );

  typedef struct {
    int       at_cyc;
    logic [7:0] d;
    bit       pe;
    bit       fe;
  } ev_t;

  ev_t  evq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   last_at = 0;
  logic [7:0] m_data = '0;
  bit   m_valid, m_perr, m_ferr, m_ovr;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, event times precomputed by the sender
  always @(posedge clk_i) begin
    ev_t ev;
    cyc++;
    if (!rst_ni) begin
      m_data = '0; m_valid = 0; m_perr = 0; m_ferr = 0; m_ovr = 0;
    end else if (evq.size() > 0 && evq[0].at_cyc == cyc) begin
      ev = evq.pop_front();
      m_ovr   = m_valid && !rd_i;
      m_data  = ev.d;
      m_perr  = ev.pe;
      m_ferr  = ev.fe;
      m_valid = 1;
    end else if (rd_i) begin
      m_valid = 0; m_perr = 0; m_ferr = 0; m_ovr = 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(data_o == m_data, "R3 data", {8'h0, data_o}, {8'h0, m_data});
      chk(status_o[0] == m_valid, "R3 valid", status_o, {15'h0, m_valid});
      chk(status_o[3] == m_perr, "R5 parity", status_o, {15'h0, m_perr});
      chk(status_o[4] == m_ferr, "R6 framing", status_o, {15'h0, m_ferr});
      chk(status_o[5] == m_ovr, "R7 overrun", status_o, {15'h0, m_ovr});
      chk(status_o[6] == (m_perr | m_ferr | m_ovr), "R10 any", status_o,
          {15'h0, m_perr | m_ferr | m_ovr});
      chk({status_o[9:7], status_o[2:1]} == 5'b10000, "R2 fixed", status_o, 16'h0200);
    end
  end

  task automatic send(input logic [7:0] d, input bit flip, input bit s1, input bit s2);
    int  k, nb;
    bit  pb;
    ev_t ev;
    @(negedge clk_i);
    k  = cyc;
    pb = (par_odd_i ? ~^d : ^d) ^ flip;
    nb = 8 + (par_en_i ? 1 : 0) + (two_stop_i ? 2 : 1);
    ev.at_cyc = k + 12 + 16 * nb;
    ev.d  = d;
    ev.pe = par_en_i && flip;
    ev.fe = !s1 || (two_stop_i && !s2);
    evq.push_back(ev);
    last_at = ev.at_cyc;
    rxd_i = 1'b0;
    repeat (16) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (16) @(negedge clk_i);
    end
    if (par_en_i) begin
      rxd_i = pb;
      repeat (16) @(negedge clk_i);
    end
    rxd_i = s1;
    repeat (16) @(negedge clk_i);
    if (two_stop_i) begin
      rxd_i = s2;
      repeat (16) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (24) @(negedge clk_i);
  endtask

  task automatic host_read();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(status_o == 10'h200, "R1 reset status", status_o, 16'h0200);
    chk(data_o == 8'h00, "R1 reset data", data_o, 16'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R3 plain character
    send(8'hA5, 0, 1, 1);
    chk(data_o == 8'hA5, "R3 data A5", data_o, 16'h00A5);
    chk(status_o == 10'h201, "R3 valid", status_o, 16'h0201);
    host_read();
    chk(status_o == 10'h200, "R9 read clears", status_o, 16'h0200);

    // R4 short start pulse
    @(negedge clk_i); rxd_i = 1'b0;
    repeat (4) @(negedge clk_i); rxd_i = 1'b1;
    repeat (60) @(negedge clk_i);
    chk(status_o == 10'h200, "R4 glitch ignored", status_o, 16'h0200);
    chk(data_o == 8'hA5, "R4 data unchanged", data_o, 16'h00A5);

    // R5 parity even / odd
    par_en_i = 1'b1; par_odd_i = 1'b0;
    send(8'h3C, 0, 1, 1);
    chk(status_o == 10'h201, "R5 even ok", status_o, 16'h0201);
    host_read();
    send(8'h3D, 1, 1, 1);
    chk(status_o == 10'h249, "R5 even bad R10", status_o, 16'h0249);
    host_read();
    par_odd_i = 1'b1;
    send(8'h07, 0, 1, 1);
    chk(status_o == 10'h201, "R5 odd ok", status_o, 16'h0201);
    host_read();
    send(8'h80, 1, 1, 1);
    chk(status_o == 10'h249, "R5 odd bad", status_o, 16'h0249);
    host_read();
    par_en_i = 1'b0; par_odd_i = 1'b0;

    // R6 framing, one and two stop bits
    send(8'h5A, 0, 0, 1);
    chk(status_o == 10'h251, "R6 stop low", status_o, 16'h0251);
    host_read();
    two_stop_i = 1'b1;
    send(8'h12, 0, 1, 0);
    chk(status_o == 10'h251, "R6 second stop low", status_o, 16'h0251);
    host_read();
    send(8'h34, 0, 0, 1);
    chk(status_o == 10'h251, "R6 first stop low", status_o, 16'h0251);
    host_read();
    send(8'h56, 0, 1, 1);
    chk(status_o == 10'h201, "R6 two stops ok", status_o, 16'h0201);
    host_read();
    two_stop_i = 1'b0;

    // R7 overrun
    send(8'h11, 0, 1, 1);
    send(8'h22, 0, 1, 1);
    chk(data_o == 8'h22, "R7 newer data", data_o, 16'h0022);
    chk(status_o == 10'h261, "R7 overrun R10", status_o, 16'h0261);
    host_read();

    // R8 flags replaced by the newer character
    send(8'h99, 0, 0, 1);
    chk(status_o == 10'h251, "R8 first framing", status_o, 16'h0251);
    send(8'h33, 0, 1, 1);
    chk(status_o == 10'h261, "R8 framing replaced", status_o, 16'h0261);
    host_read();
    chk(status_o == 10'h200, "R9 all cleared", status_o, 16'h0200);

    // R11 read in the store cycle
    send(8'h44, 0, 1, 1);
    last_at = 0;
    fork
      send(8'h55, 0, 1, 1);
      begin
        @(negedge clk_i);
        while (last_at == 0 || cyc != last_at - 1) @(negedge clk_i);
        rd_i = 1'b1;
        @(negedge clk_i);
        rd_i = 1'b0;
        chk(status_o == 10'h201, "R11 store wins", status_o, 16'h0201);
      end
    join
    chk(data_o == 8'h55, "R11 data", data_o, 16'h0055);
    chk(status_o == 10'h201, "R11 no overrun", status_o, 16'h0201);
    host_read();
    chk(status_o == 10'h200, "R9 final read", status_o, 16'h0200);

    repeat (10) @(negedge clk_i);
    finish_run();
  end
endmodule